// File: doc/BRIEF.md
# Edge-Counted Toggle Waveform Generator

This block shapes a single output line by flipping its level at chosen counts of falling edges on an external clock. Before a run, a short list of count values is written into a small on-block table through a plain write port. A start pulse clears the edge counter and arms the first list value. Each time the counter reaches the armed value, the output inverts and the following list value is picked up at once. There is no shadow register, so the new value governs the very next falling edge.

A run ends in one of three ways: the programmed number of entries has been used, the next entry holds the all-ones end marker, or the number of entries is zero at start. A level input can hold the output high at any time. When the input is released, the output keeps that level and the run carries on from the same table position. The table reload needs one external edge, so a list value that does not lie at least two edges after the previous toggle arrives late. Such a value sets a sticky overrun flag and is applied one edge after the previous toggle. The external clock is brought into the system clock domain through a two-flop synchronizer. The external clock has to run several times slower than the system clock.

Top module: `edge_toggle_gen`

## Requirements
- R1: After reset, wave_out, done and overrun are all 0.
- R2: The edge counter increments by one on each falling edge of ext_clk, after a two-flop synchronizer; rising edges are not counted. A start pulse clears the counter to zero, so the first falling edge after start has count 1. A second start in mid-run restarts the count.
- R3: When the count reached on a falling edge equals the armed compare value, wave_out inverts. Edges that do not match leave it unchanged.
- R4: Table entry 0 is armed at start, and each match fetches the next entry in ascending address order (1, 2, 3, ...).
- R5: If the entry that would be fetched after a match holds 0xFFFF, the run ends at that match: done goes to 1 and no later edge toggles wave_out.
- R6: After entry_count matches the run ends with done = 1. An entry_count of 0 sets done on the cycle after start and gives no toggles. An entry_count greater than DEPTH is treated as DEPTH.
- R7: While force_high is 1, wave_out is 1. After release, wave_out keeps level 1 and later matches toggle it from there, using the same table position.
- R8: A fetched entry must be at least 2 greater than the count of the match that fetched it. If it is not, overrun goes to 1 and the entry is applied (toggle plus next fetch) on the very next falling edge.
- R9: done and overrun stay set until the next start, and start clears both. Start leaves the level of wave_out unchanged.
- R10: A cycle with wr_en = 1 stores wr_data in table entry wr_addr; the stored values define the toggle points of the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External clock whose falling edges are counted |
| start | input | 1 | One-cycle pulse: clear counter, arm entry 0, clear flags |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | $clog2(DEPTH) (3) | Table entry to write |
| wr_data | input | CW (16) | Compare value to store |
| entry_count | input | $clog2(DEPTH+1) (4) | Number of table entries used by a run, sampled at start |
| force_high | input | 1 | Holds wave_out at 1 while asserted |
| wave_out | output | 1 | Generated waveform |
| done | output | 1 | Run has ended |
| overrun | output | 1 | A toggle point arrived before its reload completed |

## Verification
The bench builds the block with its defaults, DEPTH = 8 and CW = 16. With these values the whole eight-entry table is used in one run. The 4-bit entry_count can also carry values from 9 to 15, which brings the clamp to DEPTH within reach. The end marker, a zero entry count, a one-edge spacing that triggers overrun, a forced level that is released mid-run, and a restart in mid-run are each driven with their own directed sequence.

// File: rtl/etg_pkg.sv
// Shared types for the edge-counted toggle generator.
package etg_pkg;

    // Sequencer phase: idle, armed on a compare value, or waiting one edge for a reload.
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMED   = 2'd1,
        SEQ_PENDING = 2'd2
    } seq_state_t;

endpackage

// File: rtl/etg_edge_sync.sv
// Brings the external clock into the system domain and flags its falling edges.
// Assumes ext_clk stays at each level for at least two system clock cycles.
module etg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic fall
);
    logic sync_a, sync_b, sync_prev;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a    <= 1'b0;
            sync_b    <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync_a    <= ext_clk;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    // A falling edge is a high level followed by a low level.
    assign fall = sync_prev & ~sync_b;

    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/etg_table.sv
// Register table of compare values, with one write port and one asynchronous read port.
// Reads past the last entry return the all-ones end marker. Reset fills the table with it.
module etg_table #(
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [CW-1:0] rd_data
);
    localparam logic [CW-1:0] END_MARK = {CW{1'b1}};
    localparam logic [PW-1:0] LIMIT    = PW'(DEPTH);

    logic [CW-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Each entry captures write data when its address is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= END_MARK;
            else if (wr_en && wr_addr == AW'(g))
                entry[g] <= wr_data;
        end
    end

    // Read mux with out-of-range indices mapped to the end marker.
    always_comb begin
        if (rd_idx < LIMIT)
            rd_data = entry[rd_idx[AW-1:0]];
        else
            rd_data = END_MARK;
    end

endmodule

// File: rtl/etg_sequencer.sv
// Counts synchronized falling edges, compares against the armed value, toggles the
// waveform and fetches the next table entry on each match. A fetched value is armed
// on the following edge; a value already reached by then is applied late and flags overrun.
// Assumes start is a single-cycle pulse given while no falling edge is being reported.
module etg_sequencer
    import etg_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          fall,
    input  logic          force_high,
    input  logic [PW-1:0] entry_count,
    input  logic [CW-1:0] rd_data,
    output logic [PW-1:0] rd_idx,
    output logic          wave_out,
    output logic          done,
    output logic          overrun
);
    localparam logic [CW-1:0] END_MARK = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
    localparam logic [PW-1:0] LIMIT    = PW'(DEPTH);

    seq_state_t    state;
    logic [CW-1:0] cnt, cnt_next, cmp_val;
    logic [PW-1:0] ptr, lim, lim_in;
    logic          hit, toggle;

    // Saturating next count and clamped entry count.
    always_comb begin
        cnt_next = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        lim_in   = (entry_count > LIMIT) ? LIMIT : entry_count;
    end

    // Match rule: exact equality when armed; late reach when still pending.
    always_comb begin
        unique case (state)
            SEQ_ARMED:   hit = (cnt_next == cmp_val);
            SEQ_PENDING: hit = (cmp_val <= cnt_next);
            default:     hit = 1'b0;
        endcase
        toggle = fall && !start && hit;
    end

    // Table read address: entry 0 at start, otherwise the next unread entry.
    assign rd_idx = start ? '0 : ptr;

    // Run control: counter, compare register, read pointer and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            cmp_val <= '0;
            ptr     <= '0;
            lim     <= '0;
            done    <= 1'b0;
            overrun <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            ptr     <= PW'(1);
            cmp_val <= rd_data;
            lim     <= lim_in;
            overrun <= 1'b0;
            if (lim_in == '0 || rd_data == END_MARK) begin
                state <= SEQ_IDLE;
                done  <= 1'b1;
            end else begin
                state <= SEQ_ARMED;
                done  <= 1'b0;
            end
        end else if (fall && state != SEQ_IDLE) begin
            cnt <= cnt_next;
            if (hit) begin
                if (state == SEQ_PENDING)
                    overrun <= 1'b1;
                if (ptr >= lim || rd_data == END_MARK) begin
                    state <= SEQ_IDLE;
                    done  <= 1'b1;
                end else begin
                    cmp_val <= rd_data;
                    ptr     <= ptr + 1'b1;
                    state   <= SEQ_PENDING;
                end
            end else if (state == SEQ_PENDING) begin
                state <= SEQ_ARMED;
            end
        end
    end

    // Output level: forced high on request, otherwise inverted on each match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_out <= 1'b0;
        else if (force_high)
            wave_out <= 1'b1;
        else if (toggle)
            wave_out <= ~wave_out;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !start) |=> $stable(cnt));

    // R3
    wave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !force_high) |=> $stable(wave_out));

    // R5
    no_toggle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !force_high) |=> $stable(wave_out));

    // R6
    empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && entry_count == '0) |=> done);

    // R7
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_high |=> wave_out);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start) |=> overrun);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9
    start_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !overrun);

endmodule

// File: rtl/edge_toggle_gen.sv
// Top level: synchronizer, compare table and sequencer for the toggle waveform generator.
// Assumes DEPTH >= 2 and an external clock well below the system clock rate.
module edge_toggle_gen #(
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_clk,
    input  logic          start,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [PW-1:0] entry_count,
    input  logic          force_high,
    output logic          wave_out,
    output logic          done,
    output logic          overrun
);
    logic          fall;
    logic [PW-1:0] rd_idx;
    logic [CW-1:0] rd_data;

    etg_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .fall    (fall)
    );

    etg_table #(.DEPTH(DEPTH), .CW(CW), .AW(AW), .PW(PW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    etg_sequencer #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .fall        (fall),
        .force_high  (force_high),
        .entry_count (entry_count),
        .rd_data     (rd_data),
        .rd_idx      (rd_idx),
        .wave_out    (wave_out),
        .done        (done),
        .overrun     (overrun)
    );

endmodule

// File: tb/edge_toggle_gen_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module edge_toggle_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b1;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  entry_count = '0;
    logic        force_high = 1'b0;
    logic        wave_out, done, overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    edge_toggle_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .start(start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .entry_count(entry_count), .force_high(force_high),
        .wave_out(wave_out), .done(done), .overrun(overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start(input int cnt);
        @(negedge clk);
        entry_count = 4'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One external period: falling edge then rising edge, each held 4 system cycles.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b0;
            repeat (4) @(negedge clk);
            ext_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1", "wave_out", int'(wave_out), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "overrun", int'(overrun), 0);
    endtask

    task automatic t_basic;
        wr(0, 3); wr(1, 5); wr(2, 9);                  // R10 table writes
        pulse_start(3);
        chk("R9", "wave after start", int'(wave_out), 0);
        tick(2);
        chk("R3", "no toggle before match", int'(wave_out), 0);
        tick(1);
        chk("R3", "toggle at edge 3", int'(wave_out), 1);
        tick(1);
        chk("R3", "hold at edge 4", int'(wave_out), 1);
        tick(1);
        chk("R4", "second entry at edge 5", int'(wave_out), 0);
        tick(3);
        chk("R4", "hold through edge 8", int'(wave_out), 0);
        chk("R6", "not done at edge 8", int'(done), 0);
        tick(1);
        chk("R10", "third entry at edge 9", int'(wave_out), 1);
        chk("R6", "done after count", int'(done), 1);
        tick(3);
        chk("R6", "no toggle after done", int'(wave_out), 1);
    endtask

    task automatic t_sentinel;
        wr(0, 2); wr(1, 4); wr(2, 16'hFFFF); wr(3, 7);
        pulse_start(4);
        chk("R9", "start clears done", int'(done), 0);
        chk("R9", "start keeps wave", int'(wave_out), 1);
        tick(2);
        chk("R3", "toggle at edge 2", int'(wave_out), 0);
        tick(2);
        chk("R5", "toggle at edge 4", int'(wave_out), 1);
        chk("R5", "done at end marker", int'(done), 1);
        tick(4);
        chk("R5", "no toggle at edge 7", int'(wave_out), 1);
    endtask

    task automatic t_empty;
        pulse_start(0);
        chk("R6", "done on zero count", int'(done), 1);
        tick(3);
        chk("R6", "no toggle on zero count", int'(wave_out), 1);
    endtask

    task automatic t_clamp;
        for (int i = 0; i < 8; i++) wr(i, 2 * i + 1);
        pulse_start(15);
        tick(1);
        chk("R6", "first toggle at edge 1", int'(wave_out), 0);
        tick(13);
        chk("R6", "not done at edge 14", int'(done), 0);
        chk("R6", "seven toggles by edge 14", int'(wave_out), 0);
        tick(1);
        chk("R6", "done after DEPTH entries", int'(done), 1);
        chk("R6", "eighth toggle at edge 15", int'(wave_out), 1);
        tick(2);
        chk("R6", "stopped after clamp", int'(wave_out), 1);
    endtask

    task automatic t_overrun;
        wr(0, 3); wr(1, 4); wr(2, 8);
        pulse_start(3);
        tick(3);
        chk("R8", "toggle at edge 3", int'(wave_out), 0);
        chk("R8", "no overrun yet", int'(overrun), 0);
        tick(1);
        chk("R8", "overrun at edge 4", int'(overrun), 1);
        chk("R8", "late toggle at edge 4", int'(wave_out), 1);
        tick(4);
        chk("R8", "next entry at edge 8", int'(wave_out), 0);
        chk("R9", "overrun sticky", int'(overrun), 1);
        chk("R8", "done after overrun run", int'(done), 1);
    endtask

    task automatic t_force;
        wr(0, 4); wr(1, 6);
        @(negedge clk); force_high = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "forced high", int'(wave_out), 1);
        pulse_start(2);
        chk("R9", "start clears overrun", int'(overrun), 0);
        tick(2);
        @(negedge clk); force_high = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", "level kept after release", int'(wave_out), 1);
        tick(2);
        chk("R7", "toggle from forced level at edge 4", int'(wave_out), 0);
        tick(2);
        chk("R7", "table position kept at edge 6", int'(wave_out), 1);
        chk("R7", "done after forced run", int'(done), 1);
    endtask

    task automatic t_restart;
        wr(0, 5); wr(1, 16'hFFFF);
        pulse_start(2);
        tick(3);
        pulse_start(2);
        tick(3);
        chk("R2", "count restarted", int'(wave_out), 1);
        tick(1);
        chk("R2", "no toggle at restarted edge 4", int'(wave_out), 1);
        tick(1);
        chk("R2", "toggle at restarted edge 5", int'(wave_out), 0);
        chk("R5", "done after restart", int'(done), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_sentinel();
        t_empty();
        t_clamp();
        t_overrun();
        t_force();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule